// File: doc/BRIEF.md
# Character LCD Bus Cycle Generator

This block sits between a host and the parallel port of a character dot-matrix LCD module. Each request carries a register-select level (high for character data, low for an instruction), a direction (high to read from the module, low to write to it) and one byte. The block turns each request into one or two enable strobes on the module pins. Every timing minimum is met by counting system clock cycles. Each minimum is given in nanoseconds as a parameter and converted by ceiling division by the clock period, with at least one cycle per window.

In 8-bit mode a byte takes one strobe on all eight data pins. In 4-bit mode it takes two strobes on the upper four pins, the high nibble first. For writes, the block drives the data pins and raises an output enable for the pad tri-state. For reads, it keeps the pads released. It captures the module's data at the end of each strobe and joins the two halves of a 4-bit read into one byte. A one-cycle `done` pulse ends every transaction and presents the read byte.

The controller runs through seven states:
- IDLE: `req_ready` is high; an accepted request goes to SETUP.
- SETUP: the select lines settle before the strobe; the state goes to STROBE when its window expires.
- STROBE: the enable line is high. It goes to KEEP after the first strobe of a 4-bit byte, otherwise to TAIL.
- KEEP: holds the first nibble after the fall, then goes to SWAP.
- SWAP: presents the low nibble and completes the low time, then goes back to STROBE.
- TAIL: holds the select lines and data after the last fall, then goes to DONE.
- DONE: the one-cycle completion state; it returns to IDLE.

Top module: `chr_lcd_cycle`

## Requirements
- R1: `lcd_rs` and `lcd_rw` equal the accepted request's select and direction from the cycle after acceptance until `done`, and do not change while `lcd_en` is high or during the cycles after each fall.
- R2: `lcd_en` rises exactly SETUP_CYC = max(1, ceil(140 ns / period)) cycles after the accepting edge (14 at 10 ns).
- R3: Every enable pulse lasts exactly HIGH_CYC cycles, the largest of ceil(450 ns), ceil(195 ns) and ceil(320 ns) over the period (45 at 10 ns).
- R4: In 4-bit mode the enable line stays low for LOW_CYC = max(HOLD_CYC+1, ceil(1000 ns / period) − HIGH_CYC) cycles between the two strobes (55 at 10 ns), so the strobe period is at least 1 µs.
- R5: On a write, `lcd_doe` is high from SETUP through TAIL. `lcd_dout` is constant while `lcd_en` is high and for HOLD_CYC = max(1, ceil(10 ns / period)) cycles after each fall.
- R6: In 8-bit mode one strobe carries the full byte on `lcd_dout[7:0]`. In 4-bit mode two strobes carry bits 7..4 and then bits 3..0, both on `lcd_dout[7:4]`, with `lcd_dout[3:0]` at zero.
- R7: `lcd_doe` is low for the whole of a read, in IDLE and in DONE.
- R8: A read samples `lcd_din` in the last high cycle of each strobe. In 8-bit mode `rd_data` is that byte. In 4-bit mode `rd_data` is the first strobe's `lcd_din[7:4]` above the second strobe's `lcd_din[7:4]`, and `lcd_din[3:0]` is ignored.
- R9: `done` is high for exactly one cycle, TAIL_CYC = max(HOLD_CYC, LOW_CYC − SETUP_CYC) cycles after the last fall (41 at 10 ns). `req_ready` is high only in IDLE and never while `lcd_en` is high.
- R10: `mode_4bit` is sampled only at acceptance; changing it during a transaction does not change the strobe count.
- R11: After reset `lcd_en`, `lcd_doe` and `done` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_4bit | input | 1 | 1 = 4-bit data mode, 0 = 8-bit; sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_rs | input | 1 | Register select: 1 data, 0 instruction |
| req_rw | input | 1 | Direction: 1 read from module, 0 write |
| req_data | input | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Assembled read byte, valid with `done` |
| lcd_rs | output | 1 | Register-select pin |
| lcd_rw | output | 1 | Read/write pin |
| lcd_en | output | 1 | Enable strobe pin |
| lcd_dout | output | 8 | Data driven toward the pins |
| lcd_doe | output | 1 | Output enable for the data pad tri-states |
| lcd_din | input | 8 | Data received from the pins |

## Verification
The assertions check on every cycle the properties that hold at all times. These are: a minimum enable high width and a minimum low time before each rise, stable select and data lines during a strobe, pads released whenever the direction is a read, a single-cycle `done`, and no `req_ready` during a strobe. Exact cycle counts, the order of the nibbles, hold after each fall, assembly of the read byte and the sampling of the mode at acceptance can only be shown by the bench. The bench emulates the module on the pins and counts cycles over random and directed transactions.

// File: rtl/chr_lcd_pkg.sv
package chr_lcd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_KEEP,
        ST_SWAP,
        ST_TAIL,
        ST_DONE
    } lcd_state_e;

    // ceiling of ns/period, never below one cycle
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/chr_lcd_timer.sv
module chr_lcd_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // a window of N cycles: load N-1, count to zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val - CW'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/chr_lcd_datapath.sv
module chr_lcd_datapath (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture,
    input  logic       req_rs,
    input  logic       req_rw,
    input  logic [7:0] req_data,
    input  logic       req_mode4,
    input  logic       use_low,
    input  logic       sample,
    input  logic [7:0] lcd_din,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       mode4_q,
    output logic [7:0] lcd_dout,
    output logic [7:0] rd_data
);
    logic [7:0] byte_q;
    logic [7:0] rd_q;
    logic [3:0] nib;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcd_rs  <= 1'b0;
            lcd_rw  <= 1'b0;
            mode4_q <= 1'b0;
            byte_q  <= '0;
        end else if (capture) begin
            lcd_rs  <= req_rs;
            lcd_rw  <= req_rw;
            mode4_q <= req_mode4;
            byte_q  <= req_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (sample) begin
            if (!mode4_q) begin
                rd_q <= lcd_din;
            end else if (!use_low) begin
                rd_q[7:4] <= lcd_din[7:4];
            end else begin
                rd_q[3:0] <= lcd_din[7:4];
            end
        end
    end

    always_comb begin
        nib = use_low ? byte_q[3:0] : byte_q[7:4];
        if (lcd_rw) begin
            lcd_dout = '0;
        end else if (mode4_q) begin
            lcd_dout = {nib, 4'b0000};
        end else begin
            lcd_dout = byte_q;
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/chr_lcd_fsm.sv
module chr_lcd_fsm
    import chr_lcd_pkg::*;
#(
    parameter int unsigned CW        = 8,
    parameter int unsigned SETUP_CYC = 14,
    parameter int unsigned HIGH_CYC  = 45,
    parameter int unsigned HOLD_CYC  = 1,
    parameter int unsigned GAP_CYC   = 54,
    parameter int unsigned TAIL_CYC  = 41
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          mode4_q,
    input  logic          rw_q,
    input  logic          expired,
    output logic          req_ready,
    output logic          capture,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          use_low,
    output logic          sample,
    output logic          lcd_en,
    output logic          lcd_doe,
    output logic          done
);
    lcd_state_e state, nxt;

    // next state and timer loads
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = CW'(1);
        capture  = 1'b0;
        sample   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt      = ST_SETUP;
                    capture  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(SETUP_CYC);
                end
            end
            ST_SETUP: begin
                if (expired) begin
                    nxt      = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(HIGH_CYC);
                end
            end
            ST_STROBE: begin
                if (expired) begin
                    sample   = 1'b1;
                    tmr_load = 1'b1;
                    if (mode4_q && !use_low) begin
                        nxt     = ST_KEEP;
                        tmr_val = CW'(HOLD_CYC);
                    end else begin
                        nxt     = ST_TAIL;
                        tmr_val = CW'(TAIL_CYC);
                    end
                end
            end
            ST_KEEP: begin
                if (expired) begin
                    nxt      = ST_SWAP;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(GAP_CYC);
                end
            end
            ST_SWAP: begin
                if (expired) begin
                    nxt      = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(HIGH_CYC);
                end
            end
            ST_TAIL: begin
                if (expired) nxt = ST_DONE;
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register and nibble select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            use_low <= 1'b0;
        end else begin
            state <= nxt;
            if (capture) begin
                use_low <= 1'b0;
            end else if (state == ST_KEEP && expired) begin
                use_low <= 1'b1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        lcd_en    = 1'b0;
        lcd_doe   = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:   req_ready = 1'b1;
            ST_SETUP:  lcd_doe   = !rw_q;
            ST_STROBE: begin
                lcd_en  = 1'b1;
                lcd_doe = !rw_q;
            end
            ST_KEEP:   lcd_doe   = !rw_q;
            ST_SWAP:   lcd_doe   = !rw_q;
            ST_TAIL:   lcd_doe   = !rw_q;
            ST_DONE:   done      = 1'b1;
            default:   req_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/chr_lcd_cycle.sv
module chr_lcd_cycle
    import chr_lcd_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_SEL_SU_NS   = 140,
    parameter int unsigned T_SEL_HD_NS   = 10,
    parameter int unsigned T_EN_HIGH_NS  = 450,
    parameter int unsigned T_EN_CYC_NS   = 1000,
    parameter int unsigned T_WR_SU_NS    = 195,
    parameter int unsigned T_WR_HD_NS    = 10,
    parameter int unsigned T_RD_VAL_NS   = 320
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_4bit,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_rs,
    input  logic       req_rw,
    input  logic [7:0] req_data,
    output logic       done,
    output logic [7:0] rd_data,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en,
    output logic [7:0] lcd_dout,
    output logic       lcd_doe,
    input  logic [7:0] lcd_din
);
    localparam int unsigned SETUP_CYC = ns_to_cyc(T_SEL_SU_NS, CLK_PERIOD_NS);
    localparam int unsigned HOLD_CYC  = max2(ns_to_cyc(T_SEL_HD_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_WR_HD_NS, CLK_PERIOD_NS));
    localparam int unsigned HIGH_CYC  = max2(ns_to_cyc(T_EN_HIGH_NS, CLK_PERIOD_NS),
                                        max2(ns_to_cyc(T_WR_SU_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_RD_VAL_NS, CLK_PERIOD_NS)));
    localparam int unsigned PER_CYC   = ns_to_cyc(T_EN_CYC_NS, CLK_PERIOD_NS);
    localparam int unsigned LOW_RAW   = (PER_CYC > HIGH_CYC) ? PER_CYC - HIGH_CYC : 0;
    localparam int unsigned LOW_CYC   = max2(HOLD_CYC + 1, LOW_RAW);
    localparam int unsigned GAP_CYC   = LOW_CYC - HOLD_CYC;
    localparam int unsigned TAIL_CYC  = max2(HOLD_CYC,
                                             (LOW_CYC > SETUP_CYC) ? LOW_CYC - SETUP_CYC : 1);
    localparam int unsigned MAX_CYC   = max2(max2(SETUP_CYC, HIGH_CYC),
                                             max2(GAP_CYC, TAIL_CYC));
    localparam int unsigned CW        = $clog2(MAX_CYC + 1);

    logic          capture;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          expired;
    logic          use_low;
    logic          sample;
    logic          mode4_q;

    chr_lcd_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    chr_lcd_fsm #(
        .CW        (CW),
        .SETUP_CYC (SETUP_CYC),
        .HIGH_CYC  (HIGH_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .GAP_CYC   (GAP_CYC),
        .TAIL_CYC  (TAIL_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .mode4_q   (mode4_q),
        .rw_q      (lcd_rw),
        .expired   (expired),
        .req_ready (req_ready),
        .capture   (capture),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .use_low   (use_low),
        .sample    (sample),
        .lcd_en    (lcd_en),
        .lcd_doe   (lcd_doe),
        .done      (done)
    );

    chr_lcd_datapath u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .req_rs    (req_rs),
        .req_rw    (req_rw),
        .req_data  (req_data),
        .req_mode4 (mode_4bit),
        .use_low   (use_low),
        .sample    (sample),
        .lcd_din   (lcd_din),
        .lcd_rs    (lcd_rs),
        .lcd_rw    (lcd_rw),
        .mode4_q   (mode4_q),
        .lcd_dout  (lcd_dout),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/chr_lcd_cycle_chk.sv
module chr_lcd_cycle_chk #(
    parameter int unsigned HIGH_MIN  = 45,
    parameter int unsigned SETUP_MIN = 14
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       done,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic       lcd_en,
    input logic [7:0] lcd_dout,
    input logic       lcd_doe
);
    logic [15:0] hi_len;
    logic [15:0] lo_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len <= '0;
            lo_len <= '0;
        end else begin
            if (lcd_en) begin
                hi_len <= (hi_len == 16'hFFFF) ? hi_len : hi_len + 16'd1;
                lo_len <= '0;
            end else begin
                hi_len <= '0;
                lo_len <= (lo_len == 16'hFFFF) ? lo_len : lo_len + 16'd1;
            end
        end
    end

    AST_EN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_en) |-> hi_len >= 16'(HIGH_MIN)); // R3

    AST_SEL_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_en) |-> lo_len >= 16'(SETUP_MIN)); // R2

    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_en && $past(lcd_en)) |-> ($stable(lcd_rs) && $stable(lcd_rw))); // R1

    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_en && $past(lcd_en)) |-> $stable(lcd_dout)); // R5

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_rw |-> !lcd_doe); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !lcd_en); // R9
endmodule

bind chr_lcd_cycle chr_lcd_cycle_chk #(
    .HIGH_MIN  (HIGH_CYC),
    .SETUP_MIN (SETUP_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .lcd_rs    (lcd_rs),
    .lcd_rw    (lcd_rw),
    .lcd_en    (lcd_en),
    .lcd_dout  (lcd_dout),
    .lcd_doe   (lcd_doe)
);

// File: tb/test_chr_lcd_cycle.sv
module test_chr_lcd_cycle;

    function automatic int cdiv(input int ns, input int per);
        int c;
        c = (ns + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int PER    = 10;
    localparam int SETUP_E = cdiv(140, PER);
    localparam int HOLD_E  = cdiv(10, PER);
    localparam int HIGH_E  = cdiv(450, PER);
    localparam int LOW_E   = cdiv(1000, PER) - HIGH_E;
    localparam int TAIL_E  = LOW_E - SETUP_E;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_4bit = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_rs = 1'b0;
    logic       req_rw = 1'b0;
    logic [7:0] req_data = '0;
    logic       done;
    logic [7:0] rd_data;
    logic       lcd_rs, lcd_rw, lcd_en, lcd_doe;
    logic [7:0] lcd_dout;
    logic [7:0] lcd_din = 8'h00;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    chr_lcd_cycle i_chr_lcd_cycle (
        .clk(clk), .rst_n(rst_n), .mode_4bit(mode_4bit),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_rs(req_rs), .req_rw(req_rw), .req_data(req_data),
        .done(done), .rd_data(rd_data),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en),
        .lcd_dout(lcd_dout), .lcd_doe(lcd_doe), .lcd_din(lcd_din)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] exp_pins(input logic [7:0] b, input bit m4, input int s);
        if (!m4) return b;
        return (s == 0) ? {b[7:4], 4'h0} : {b[3:0], 4'h0};
    endfunction

    // one transaction; the bench plays the module on the pins
    task automatic xfer(input bit rs, input bit rw, input logic [7:0] data,
                        input bit m4, input bit flip, input logic [7:0] mod_byte);
        int cnt;
        int nstr;
        logic [7:0] ep;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
        req_valid = 1'b1; req_rs = rs; req_rw = rw; req_data = data; mode_4bit = m4;
        @(negedge clk);
        req_valid = 1'b0;
        req_data  = ~data;
        if (flip) mode_4bit = ~m4;   // R10: must not matter
        chk(req_ready == 1'b0, "R9 ready low while busy", req_ready, 0);
        nstr = m4 ? 2 : 1;
        for (int s = 0; s < nstr; s++) begin
            cnt = 0;
            while (!lcd_en && cnt < 400) begin
                if (cnt > HOLD_E - 1 || s == 0) begin
                    if (lcd_rs !== rs || lcd_rw !== rw) begin
                        chk(0, "R1 select lines", {lcd_rs, lcd_rw}, {rs, rw});
                    end
                    if (lcd_doe !== !rw) chk(0, "R5/R7 output enable", lcd_doe, !rw);
                end
                cnt++;
                @(negedge clk);
            end
            if (s == 0) chk(cnt == SETUP_E, "R2 setup cycles", cnt, SETUP_E);
            else        chk(cnt == LOW_E, "R4 low time between nibbles", cnt, LOW_E);
            ep = exp_pins(data, m4, s);
            cnt = 0;
            while (lcd_en && cnt < 400) begin
                lcd_din = m4 ? {(s == 0) ? mod_byte[7:4] : mod_byte[3:0], ~mod_byte[3:0]} : mod_byte;
                if (!rw && lcd_dout !== ep) chk(0, "R6 data pins during strobe", lcd_dout, ep);
                if (lcd_rs !== rs || lcd_rw !== rw) chk(0, "R1 select during strobe", {lcd_rs, lcd_rw}, {rs, rw});
                cnt++;
                @(negedge clk);
            end
            lcd_din = ~mod_byte;
            chk(cnt == HIGH_E, "R3 enable high cycles", cnt, HIGH_E);
            if (!rw) chk(lcd_dout === ep && lcd_doe, "R5 data hold after fall", lcd_dout, ep);
            chk(lcd_rs === rs && lcd_rw === rw, "R1 select hold after fall", {lcd_rs, lcd_rw}, {rs, rw});
        end
        cnt = 0;
        while (!done && cnt < 400) begin
            if (lcd_en) begin
                chk(0, "R6/R10 unexpected extra strobe", 1, 0);
                cnt = 400;
            end
            cnt++;
            @(negedge clk);
        end
        chk(cnt == TAIL_E, "R9 cycles from last fall to done", cnt, TAIL_E);
        chk(lcd_doe == 1'b0, "R7 pads released at done", lcd_doe, 0);
        if (rw) chk(rd_data === mod_byte, "R8 read byte", rd_data, mod_byte);
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", done, 0);
        chk(req_ready == 1'b1 && lcd_doe == 1'b0, "R7/R9 idle after done", {req_ready, lcd_doe}, 2);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lcd_en == 0 && lcd_doe == 0 && done == 0 && req_ready == 1,
            "R11 reset state", {lcd_en, lcd_doe, done, req_ready}, 1);
        // directed corners
        xfer(1'b1, 1'b0, 8'hA5, 1'b0, 1'b0, 8'h00);   // 8-bit data write
        xfer(1'b0, 1'b0, 8'h3C, 1'b1, 1'b0, 8'h00);   // 4-bit instruction write
        xfer(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 8'hC7);   // 8-bit read
        xfer(1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h9E);   // 4-bit read, R8 concatenation
        xfer(1'b1, 1'b0, 8'hF0, 1'b1, 1'b1, 8'h00);   // R10 mode flip to 8-bit mid-transfer
        xfer(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 8'h5B);   // R10 mode flip to 4-bit mid-transfer
        // random mix
        for (int i = 0; i < 30; i++) begin
            xfer(1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom),
                 1'($urandom), 8'($urandom));
        end
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait (cyc > 150000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule